// File: doc/BRIEF.md
# Interval Timer with Delayed Reload

A 16-bit down-counting interval timer for a peripheral adapter. It runs on the system clock but moves only on cycles where the bus-cycle clock enable `ce` is high. Software writes a low latch byte, then a high byte. The high-byte write starts a count from `{high byte, low latch}`. An interrupt flag is raised when the count runs out.

A mode bit in the control register picks one of two modes. In one-shot mode the counter runs through zero and wraps, and it raises the interrupt only once for each high-byte write. In free-run mode the counter shows `FFFF` for one enabled cycle after zero and reloads on the next one. So with latch value N, interrupts come every N+2 enabled cycles.

A small state machine runs the reload sequence. It has three states. `ST_DISARMED` means counting with no interrupt pending for this load. `ST_ARMED` means the next zero raises the interrupt. `ST_WRAP` means the counter shows `FFFF` and reloads on the next enabled cycle.

The transitions are:
- A high-byte write moves any state to `ST_ARMED`.
- In `ST_ARMED`, an enabled zero moves to `ST_WRAP` in free-run mode and to `ST_DISARMED` in one-shot mode.
- In `ST_DISARMED`, an enabled zero with free-run set moves to `ST_WRAP`.
- In `ST_WRAP`, any enabled cycle moves to `ST_ARMED`.

Top module: `interval_timer`

## Requirements
- R1: After reset the count is `FFFF`, the interrupt flag is 0 and the state is `ST_DISARMED`.
- R2: A write to address `A_HI` (default 5) loads the count with `{wr_data, low latch}`, stores `wr_data` as the high latch and clears the interrupt flag.
- R3: The count changes only on cycles where `ce` is 1 or a high-byte write occurs; otherwise it holds.
- R4: Bit 6 of the value written to address `A_CTL` (default 11) selects free-run mode when 1 and one-shot mode when 0.
- R5: In both modes, an enabled cycle with count `0000` makes the count `FFFF`.
- R6: In free-run mode, the enabled cycle after that `FFFF` loads `{high latch, low latch}`. The first interrupt after a load comes N+1 enabled cycles after the load, and each later one comes N+2 enabled cycles after the one before.
- R7: The interrupt flag is set by the enabled cycle at count `0000`, so it reads 1 together with `FFFF`. It stays set until `irq_clr` or a high-byte write clears it. A set in the same cycle as `irq_clr` wins.
- R8: In one-shot mode the counter wraps with no reload, and no second interrupt occurs until the next high-byte write.
- R9: A high-byte write in the same cycle as an enabled reload or decrement takes priority over both.
- R10: A write to address `A_LO` (default 4) updates only the low latch. It changes neither the count nor the interrupt flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Bus-cycle clock enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW (4) | Register write address |
| wr_data | input | DW (8) | Register write data |
| irq_clr | input | 1 | Clears the interrupt flag |
| count_o | output | 2*DW (16) | Current count |
| irq_o | output | 1 | Interrupt flag |

## Verification
The bench builds the block with its default parameters: a byte-wide bus and a 16-bit count. This makes the full-range latch value `FFFF` reachable, so a complete 65537-cycle free-run period and a whole one-shot wrap back through zero can both be measured. Latch values 0 and 1 exercise the shortest reload paths. A half-rate `ce` pattern shows that periods are counted in enabled cycles, not clock cycles.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    typedef enum logic [1:0] {
        ST_DISARMED = 2'd0,
        ST_ARMED    = 2'd1,
        ST_WRAP     = 2'd2
    } tmr_state_e;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int A_LO     = 4,
    parameter int A_HI     = 5,
    parameter int A_CTL    = 11,
    parameter int FREE_BIT = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [2*DW-1:0] latch,
    output logic            free_run,
    output logic            hi_load
);
    localparam logic [AW-1:0] ADR_LO  = AW'(A_LO);
    localparam logic [AW-1:0] ADR_HI  = AW'(A_HI);
    localparam logic [AW-1:0] ADR_CTL = AW'(A_CTL);

    logic [DW-1:0] lat_lo, lat_hi;

    assign hi_load = wr_en && (wr_addr == ADR_HI);
    assign latch   = {lat_hi, lat_lo};

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_lo   <= '0;
            lat_hi   <= '0;
            free_run <= 1'b0;
        end else if (wr_en) begin
            if (wr_addr == ADR_LO)  lat_lo   <= wr_data;
            if (wr_addr == ADR_HI)  lat_hi   <= wr_data;
            if (wr_addr == ADR_CTL) free_run <= wr_data[FREE_BIT];
        end
    end

    AST_LO_WRITE_ONLY_LO: assert property (@(posedge clk) disable iff (rst)
        wr_en && wr_addr == ADR_LO |=> lat_hi == $past(lat_hi)) else $error("lo write moved hi latch"); // R10
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
    import tmr_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ce,
    input  logic       hi_load,
    input  logic       free_run,
    input  logic       zero,
    output tmr_state_e state,
    output logic       dec_en,
    output logic       reload_en,
    output logic       fire
);
    tmr_state_e nxt;
    logic       step;

    assign step = ce && !hi_load;

    always_comb begin
        nxt = state;
        if (hi_load) begin
            nxt = ST_ARMED;
        end else if (ce) begin
            unique case (state)
                ST_DISARMED: if (zero && free_run) nxt = ST_WRAP;
                ST_ARMED:    if (zero) nxt = free_run ? ST_WRAP : ST_DISARMED;
                ST_WRAP:     nxt = ST_ARMED;
                default:     nxt = ST_DISARMED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_DISARMED;
        else     state <= nxt;
    end

    always_comb begin
        dec_en    = 1'b0;
        reload_en = 1'b0;
        fire      = 1'b0;
        unique case (state)
            ST_DISARMED: begin
                dec_en = step;
                fire   = step && zero && free_run;
            end
            ST_ARMED: begin
                dec_en = step;
                fire   = step && zero;
            end
            ST_WRAP: begin
                reload_en = step;
            end
            default: dec_en = 1'b0;
        endcase
    end

    AST_WRAP_LEAVES: assert property (@(posedge clk) disable iff (rst)
        state == ST_WRAP && ce |=> state == ST_ARMED) else $error("wrap state held"); // R6
    AST_LOAD_ARMS: assert property (@(posedge clk) disable iff (rst)
        hi_load |=> state == ST_ARMED) else $error("load did not arm"); // R8
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hi_load,
    input  logic            reload_en,
    input  logic            dec_en,
    input  logic [DW-1:0]   hi_byte,
    input  logic [2*DW-1:0] latch,
    output logic [2*DW-1:0] cnt,
    output logic            zero
);
    localparam int CW = 2 * DW;

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst)            cnt <= '1;
        else if (hi_load)   cnt <= {hi_byte, latch[DW-1:0]};
        else if (reload_en) cnt <= latch;
        else if (dec_en)    cnt <= cnt - CW'(1);
    end

    AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (rst)
        hi_load |=> cnt == {$past(hi_byte), $past(latch[DW-1:0])}) else $error("bad load value"); // R2
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !hi_load && !reload_en && !dec_en |=> $stable(cnt)) else $error("count moved while idle"); // R3
endmodule

// File: rtl/interval_timer.sv
module interval_timer
    import tmr_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 8,
    parameter int A_LO     = 4,
    parameter int A_HI     = 5,
    parameter int A_CTL    = 11,
    parameter int FREE_BIT = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ce,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  logic [DW-1:0]   wr_data,
    input  logic            irq_clr,
    output logic [2*DW-1:0] count_o,
    output logic            irq_o
);
    logic [2*DW-1:0] latch;
    logic            free_run, hi_load, zero, dec_en, reload_en, fire;
    tmr_state_e      state;

    tmr_regs #(
        .AW(AW), .DW(DW), .A_LO(A_LO), .A_HI(A_HI), .A_CTL(A_CTL), .FREE_BIT(FREE_BIT)
    ) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .latch(latch), .free_run(free_run), .hi_load(hi_load)
    );

    tmr_ctrl u_ctrl (
        .clk(clk), .rst(rst), .ce(ce), .hi_load(hi_load), .free_run(free_run),
        .zero(zero), .state(state), .dec_en(dec_en), .reload_en(reload_en), .fire(fire)
    );

    tmr_count #(.DW(DW)) u_cnt (
        .clk(clk), .rst(rst), .hi_load(hi_load), .reload_en(reload_en), .dec_en(dec_en),
        .hi_byte(wr_data), .latch(latch), .cnt(count_o), .zero(zero)
    );

    always_ff @(posedge clk) begin
        if (rst)          irq_o <= 1'b0;
        else if (hi_load) irq_o <= 1'b0;
        else if (fire)    irq_o <= 1'b1;
        else if (irq_clr) irq_o <= 1'b0;
    end

    AST_ZERO_TO_ONES: assert property (@(posedge clk) disable iff (rst)
        ce && !hi_load && count_o == '0 |=> count_o == '1) else $error("zero not followed by all ones"); // R5
    AST_RELOAD_LATCH: assert property (@(posedge clk) disable iff (rst)
        state == ST_WRAP && ce && !hi_load |=> count_o == $past(latch)) else $error("reload value wrong"); // R6
    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (rst)
        irq_o && !irq_clr && !hi_load |=> irq_o) else $error("irq dropped"); // R7
    AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (rst)
        state == ST_DISARMED && !free_run && !hi_load |=> !$rose(irq_o)) else $error("second one-shot irq"); // R8
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        hi_load |=> !irq_o) else $error("load did not clear irq"); // R9
endmodule

// File: tb/sim_interval_timer.sv
module sim_interval_timer;
    localparam int A_LO = 4, A_HI = 5, A_CTL = 11;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce = 1'b0, wr_en = 1'b0, irq_clr = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [15:0] count_o;
    logic        irq_o;

    int n_chk = 0, n_fail = 0;
    int en_cnt = 0, mark = 0;
    bit track = 1'b0;
    int exp_q[$];

    always #4 clk = ~clk;

    interval_timer u0 (
        .clk(clk), .rst(rst), .ce(ce), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .irq_clr(irq_clr), .count_o(count_o), .irq_o(irq_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 8'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            ce = 1'b1;
        end
        @(negedge clk);
        ce = 1'b0;
    endtask

    always @(posedge clk) if (ce) en_cnt <= en_cnt + 1;

    // monitor: interrupt spacing in enabled cycles vs scoreboard (R6; pulses exist only because set beats irq_clr, R7)
    always @(negedge clk) begin
        if (track && irq_o) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected irq", en_cnt - mark, -1);
            end else begin
                check("R6 irq spacing", en_cnt - mark, exp_q.pop_front());
            end
            mark = en_cnt;
        end
    end

    task automatic run_free(int n, int reps, bit half);
        wr_reg(A_CTL, 8'h40);
        wr_reg(A_LO, n & 8'hFF);
        wr_reg(A_HI, (n >> 8) & 8'hFF);
        mark = en_cnt;
        exp_q.push_back(n + 1);
        repeat (reps) exp_q.push_back(n + 2);
        track = 1'b1;
        while (exp_q.size() > 0) begin
            @(negedge clk);
            ce = half ? !ce : 1'b1;
        end
        ce = 1'b0;
        @(negedge clk);
        track = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 reset count", count_o, 16'hFFFF);
        check("R1 reset irq", irq_o, 0);

        // R10: low latch write leaves count alone
        wr_reg(A_LO, 8'h34);
        check("R10 lo write count", count_o, 16'hFFFF);
        wr_reg(A_CTL, 8'h00);
        wr_reg(A_HI, 8'h12);
        check("R2 load value", count_o, 16'h1234);
        repeat (5) @(negedge clk);
        check("R3 hold without ce", count_o, 16'h1234);
        tick(4);
        check("R3 decrement on ce", count_o, 16'h1230);

        // free-run sequence, R4 R5 R6
        wr_reg(A_CTL, 8'h40);
        wr_reg(A_LO, 8'h01);
        wr_reg(A_HI, 8'h00);
        check("R2 load 0001", count_o, 16'h0001);
        tick(1);
        check("R5 reach zero", count_o, 16'h0000);
        check("R7 no irq before zero step", irq_o, 0);
        tick(1);
        check("R5 zero to FFFF", count_o, 16'hFFFF);
        check("R7 irq with FFFF", irq_o, 1);
        tick(1);
        check("R4 R6 free-run reload", count_o, 16'h0001);
        tick(2);
        check("R5 FFFF again", count_o, 16'hFFFF);
        // R9: high write on the reload cycle wins
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(A_HI); wr_data = 8'h20; ce = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ce = 1'b0;
        check("R9 load beats reload", count_o, 16'h2001);
        check("R2 load clears irq", irq_o, 0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'(A_HI); wr_data = 8'h30; ce = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; ce = 1'b0;
        check("R9 load beats decrement", count_o, 16'h3001);

        // one-shot, R8 R7
        wr_reg(A_CTL, 8'h00);
        wr_reg(A_LO, 8'h02);
        wr_reg(A_HI, 8'h00);
        tick(2);
        check("R5 one-shot zero", count_o, 16'h0000);
        tick(1);
        check("R7 one-shot irq", irq_o, 1);
        tick(1);
        check("R8 no reload", count_o, 16'hFFFE);
        check("R7 irq sticky", irq_o, 1);
        wr_reg(A_LO, 8'h55);
        check("R10 lo write keeps irq", irq_o, 1);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        check("R7 irq_clr clears", irq_o, 0);
        tick(16'hFFFE);
        check("R8 wrapped to zero", count_o, 16'h0000);
        tick(1);
        check("R8 only one irq", irq_o, 0);
        check("R8 wraps again", count_o, 16'hFFFF);

        // scoreboard spacing runs, irq_clr held so each set shows as a pulse
        irq_clr = 1'b1;
        run_free(0, 3, 1'b0);
        run_free(1, 3, 1'b0);
        run_free(5, 3, 1'b0);
        run_free(16'h0040, 2, 1'b1);
        run_free(16'hFFFF, 1, 1'b0);
        irq_clr = 1'b0;
        finish_run();
    end
endmodule